// File: doc/BRIEF.md
# N-Dimensional Copy Descriptor Splitter

This block takes one multi-dimensional copy descriptor and produces, in order, the one-dimensional burst requests that carry it out. A descriptor has a base source address, a base destination address and a burst length in bytes. Each outer dimension adds a repetition count and its own source and destination strides. The burst is dimension 1. The outer dimensions are 2 and, when `NUM_DIM` is 3, also 3. Dimension 2 is the innermost loop and varies fastest. The repetition counter of each outer dimension has its own width parameter.

Descriptors enter on a valid/ready port. The block takes a descriptor only while it is idle. Once it holds one, `in_ready` stays low until the final burst has been handed off. Bursts leave on a valid/ready port. A burst counts as handed off on a clock edge where `out_valid` and `out_ready` are both high. The downstream side applies back-pressure by holding `out_ready` low. While it does, the offered burst and all internal progress stay frozen. `done` is high in the same cycle as the handshake of the final burst of a descriptor.

Internally, each outer dimension has a cascaded counter. For each dimension the block keeps an address pointer that marks the start of that dimension's current pass. A trailing-wrap selector counts how many consecutive low dimensions are on their last repetition. That count picks the dimension whose strides are applied next. When every dimension is on its last repetition, the descriptor is finished. No multiplier is needed.

Top module: `nd_xfer_splitter`

## Requirements
- R1: `in_ready` is 1 exactly when no descriptor is held. A descriptor is taken on a clock edge with `in_valid` and `in_ready` both high. From that edge until the edge of the final burst handshake, `in_ready` is 0 and changes on the input port have no effect. `in_ready` is 1 again in the cycle after the final handshake.
- R2: The first burst is offered (`out_valid` = 1) in the cycle after acceptance. It carries the base source and destination addresses. Every burst of the descriptor carries the accepted length on `out_len`.
- R3: Let i2 and i3 be the indices of dimensions 2 and 3. Each burst has source address base_src + i2·src_stride[0] + i3·src_stride[1], taken modulo 2^ADDR_W. The destination address is computed the same way from its own base and its own strides. Index 0 of the stride ports belongs to dimension 2.
- R4: Bursts are emitted with i2 incrementing fastest. After the last repetition of dimension 2, i2 returns to 0 and i3 advances. When several dimensions finish on the same burst, the next burst starts at the next pass of the lowest dimension that still has repetitions left.
- R5: A repetition count of 0 acts exactly like a count of 1.
- R6: Dimension 2 takes counts up to 2^REP_W_D2−1 on `in_reps_d2`. Dimension 3 takes counts up to 2^REP_W_D3−1 on `in_reps_d3`. The two widths are set independently.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` = 1 with the same `out_src`, `out_dst` and `out_len`.
- R8: A descriptor yields exactly max(1,reps2)·max(1,reps3) handshakes. `done` is 1 only during the handshake of the last one. `out_valid` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Block idle, descriptor will be taken |
| in_src | input | ADDR_W | Base source address |
| in_dst | input | ADDR_W | Base destination address |
| in_len | input | LEN_W | Burst length in bytes |
| in_reps_d2 | input | REP_W_D2 | Repetition count of dimension 2 |
| in_reps_d3 | input | REP_W_D3 | Repetition count of dimension 3 (unused when NUM_DIM is 2) |
| in_src_stride | input | (NUM_DIM-1)×ADDR_W | Source stride per outer dimension, index 0 = dimension 2 |
| in_dst_stride | input | (NUM_DIM-1)×ADDR_W | Destination stride per outer dimension, index 0 = dimension 2 |
| out_valid | output | 1 | Burst offered |
| out_ready | input | 1 | Burst taken by downstream |
| out_src | output | ADDR_W | Burst source address |
| out_dst | output | ADDR_W | Burst destination address |
| out_len | output | LEN_W | Burst length |
| done | output | 1 | Final burst of the descriptor is being handed off |

## Verification
The first burst becomes visible one cycle after the accepting edge. Each following burst becomes visible one cycle after the handshake of the one before it. `done` is combinational on the handshake of the final burst, so it shares that cycle. `in_ready` returns in the cycle after that handshake. The bench drives inputs and samples outputs on the falling edge. It sets `out_ready` first and then waits a short delay before it reads the outputs. Each falling-edge sample therefore shows the state left by the preceding rising edge, plus the combinational `done` for the handshake about to occur. For every burst it offers, the bench compares the fields against addresses computed from nested loop indices. In any cycle where the burst was stalled, it also compares them against the previous cycle's values.

// File: rtl/nd_xfer_pkg.sv
package nd_xfer_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xfer_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nd_rep_counter.sv
// Repetition counter for one outer dimension. It counts passes from zero up
// to the loaded limit. A count of zero is loaded as a single pass.
module nd_rep_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] reps,
  input  logic         inc,
  input  logic         clr,
  output logic         last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= (reps == '0) ? '0 : reps - W'(1);
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign last = (cnt_q == lim_q);

endmodule

// File: rtl/nd_wrap_select.sv
// Counts the consecutive low dimensions that are on their final pass. The
// result is the index of the dimension to advance. A result equal to N
// means that every dimension has finished.
module nd_wrap_select #(
  parameter int unsigned N   = 2,
  parameter int unsigned LVW = $clog2(N + 1)
) (
  input  logic [N-1:0]   wrap,
  output logic [LVW-1:0] level,
  output logic           all_wrap
);

  logic [N-1:0] run;

  always_comb begin
    run[0] = wrap[0];
    for (int i = 1; i < N; i++) begin
      run[i] = run[i-1] & wrap[i];
    end
  end

  assign level    = LVW'($countones(run));
  assign all_wrap = run[N-1];

endmodule

// File: rtl/nd_addr_walk.sv
// Keeps one pointer per outer dimension. Pointer j holds the address where
// dimension j's current pass begins. Advancing dimension k moves pointer k
// by its stride and copies the new value into all pointers below k.
module nd_addr_walk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NOUT = 2,
  parameter int unsigned LVW  = $clog2(NOUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [AW-1:0]            base,
  input  logic [NOUT-1:0][AW-1:0]  stride,
  input  logic                     step,
  input  logic [LVW-1:0]           level,
  output logic [AW-1:0]            cur
);

  logic [AW-1:0] ptr_q    [NOUT];
  logic [AW-1:0] stride_q [NOUT];
  logic [AW-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int j = 0; j < NOUT; j++) begin
      if (level == LVW'(j)) nxt = ptr_q[j] + stride_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NOUT; j++) begin
        ptr_q[j]    <= '0;
        stride_q[j] <= '0;
      end
    end else if (load) begin
      for (int j = 0; j < NOUT; j++) begin
        ptr_q[j]    <= base;
        stride_q[j] <= stride[j];
      end
    end else if (step && (level < LVW'(NOUT))) begin
      for (int j = 0; j < NOUT; j++) begin
        if (LVW'(j) <= level) ptr_q[j] <= nxt;
      end
    end
  end

  assign cur = ptr_q[0];

endmodule

// File: rtl/nd_xfer_splitter.sv
module nd_xfer_splitter
  import nd_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned NUM_DIM  = 3,
  parameter int unsigned REP_W_D2 = 4,
  parameter int unsigned REP_W_D3 = 3,
  localparam int unsigned NOUT    = NUM_DIM - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ADDR_W-1:0]           in_src,
  input  logic [ADDR_W-1:0]           in_dst,
  input  logic [LEN_W-1:0]            in_len,
  input  logic [REP_W_D2-1:0]         in_reps_d2,
  input  logic [REP_W_D3-1:0]         in_reps_d3,
  input  logic [NOUT-1:0][ADDR_W-1:0] in_src_stride,
  input  logic [NOUT-1:0][ADDR_W-1:0] in_dst_stride,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ADDR_W-1:0]           out_src,
  output logic [ADDR_W-1:0]           out_dst,
  output logic [LEN_W-1:0]            out_len,
  output logic                        done
);

  localparam int unsigned LVW = $clog2(NOUT + 1);

  xfer_state_e        state_q;
  logic [LEN_W-1:0]   len_q;
  logic               accept;
  logic               fire;
  logic [NOUT-1:0]    wrap;
  logic [NOUT-1:0]    inc;
  logic [NOUT-1:0]    clr;
  logic [LVW-1:0]     level;
  logic               all_wrap;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_BUSY);
  assign accept    = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign done      = fire && all_wrap;
  assign out_len   = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_BUSY;
          len_q   <= in_len;
        end
        ST_BUSY: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar d = 0; d < NOUT; d++) begin : g_dim
    localparam logic [LVW-1:0] DL = LVW'(d);
    assign inc[d] = fire && (level == DL);
    assign clr[d] = fire && (level > DL);
    if (d == 0) begin : g_inner
      nd_rep_counter #(.W(REP_W_D2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .reps(in_reps_d2),
        .inc(inc[d]), .clr(clr[d]), .last(wrap[d])
      );
    end else begin : g_outer
      nd_rep_counter #(.W(REP_W_D3)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .reps(in_reps_d3),
        .inc(inc[d]), .clr(clr[d]), .last(wrap[d])
      );
    end
  end

  nd_wrap_select #(.N(NOUT), .LVW(LVW)) u_sel (
    .wrap(wrap), .level(level), .all_wrap(all_wrap)
  );

  nd_addr_walk #(.AW(ADDR_W), .NOUT(NOUT), .LVW(LVW)) u_src_walk (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(in_src),
    .stride(in_src_stride), .step(fire), .level(level), .cur(out_src)
  );

  nd_addr_walk #(.AW(ADDR_W), .NOUT(NOUT), .LVW(LVW)) u_dst_walk (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(in_dst),
    .stride(in_dst_stride), .step(fire), .level(level), .cur(out_dst)
  );

endmodule

// File: rtl/nd_xfer_splitter_chk.sv
module nd_xfer_splitter_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_src,
  input logic [ADDR_W-1:0] in_dst,
  input logic [LEN_W-1:0]  in_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_src,
  input logic [ADDR_W-1:0] out_dst,
  input logic [LEN_W-1:0]  out_len,
  input logic              done
);

  // R1: no descriptor can be taken while a burst is pending
  a_r1_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1, R8: the block is idle right after the final handshake
  a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !out_valid));

  // R2: the first burst follows acceptance with base addresses and length
  a_r2_first_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_src == $past(in_src)
                                && out_dst == $past(in_dst) && out_len == $past(in_len)));

  // R7: a stalled burst is held unchanged
  a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src)
                                   && $stable(out_dst) && $stable(out_len)));

  // R8: completion is flagged only on a handshake
  a_r8_done_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_ready));

endmodule

bind nd_xfer_splitter nd_xfer_splitter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_src(in_src), .in_dst(in_dst), .in_len(in_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
  .out_dst(out_dst), .out_len(out_len), .done(done)
);

// File: tb/nd_xfer_splitter_bench.sv
`timescale 1ns/1ps
module nd_xfer_splitter_bench;

  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [AW-1:0]     in_src, in_dst;
  logic [LW-1:0]     in_len;
  logic [3:0]        in_reps_d2;
  logic [2:0]        in_reps_d3;
  logic [1:0][AW-1:0] in_src_stride, in_dst_stride;
  logic              out_valid, out_ready;
  logic [AW-1:0]     out_src, out_dst;
  logic [LW-1:0]     out_len;
  logic              done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  nd_xfer_splitter #(.ADDR_W(AW), .LEN_W(LW), .NUM_DIM(3), .REP_W_D2(4), .REP_W_D3(3))
  u_nd_xfer_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_len(in_len),
    .in_reps_d2(in_reps_d2), .in_reps_d3(in_reps_d3),
    .in_src_stride(in_src_stride), .in_dst_stride(in_dst_stride),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_dst(out_dst), .out_len(out_len), .done(done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 2) == 0;
    endcase
  endfunction

  task automatic run_desc(input logic [AW-1:0] bs, input logic [AW-1:0] bd, input logic [LW-1:0] ln,
                          input int r2, input int r3,
                          input logic [AW-1:0] s2, input logic [AW-1:0] s3,
                          input logic [AW-1:0] d2, input logic [AW-1:0] d3, input int mode);
    int e2, e3;
    bit first, stalled, got, last;
    logic [AW-1:0] ps, pd, es, ed;
    logic [LW-1:0] pl;
    e2 = (r2 == 0) ? 1 : r2;   // R5: zero count behaves as one
    e3 = (r3 == 0) ? 1 : r3;
    first = 1'b1; stalled = 1'b0;
    ps = '0; pd = '0; pl = '0;
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R1 idle before descriptor", 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_src = bs; in_dst = bd; in_len = ln;
    in_reps_d2 = r2[3:0]; in_reps_d3 = r3[2:0];
    in_src_stride = {s3, s2}; in_dst_stride = {d3, d2};
    for (int i3 = 0; i3 < e3; i3++) begin
      for (int i2 = 0; i2 < e2; i2++) begin
        es = bs + s2 * i2 + s3 * i3;
        ed = bd + d2 * i2 + d3 * i3;
        last = (i2 == e2 - 1) && (i3 == e3 - 1);
        got = 1'b0;
        while (!got) begin
          @(negedge clk);
          out_ready = ready_pat(mode, cyc);
          #1;
          if (first) begin
            chk(in_ready == 1'b0, "R1 ready low after accept", 64'(in_ready), 64'd0);
            // R1: junk on the input port while busy must not disturb the bursts
            in_src = ~bs; in_dst = ~bd; in_len = ~ln;
            in_reps_d2 = 4'd1; in_reps_d3 = 3'd1;
            in_src_stride = '1; in_dst_stride = '0;
            first = 1'b0;
          end
          chk(out_valid == 1'b1, "R8 burst pending", 64'(out_valid), 64'd1);
          if (stalled) begin
            chk(out_src == ps, "R7 src held", 64'(out_src), 64'(ps));
            chk(out_dst == pd, "R7 dst held", 64'(out_dst), 64'(pd));
            chk(out_len == pl, "R7 len held", 64'(out_len), 64'(pl));
          end
          if (out_ready) begin
            chk(out_src == es, "R3 R4 source address", 64'(out_src), 64'(es));
            chk(out_dst == ed, "R3 R4 destination address", 64'(out_dst), 64'(ed));
            chk(out_len == ln, "R2 burst length", 64'(out_len), 64'(ln));
            chk(done == last, "R8 done on final burst only", 64'(done), 64'(last));
            if (last) in_valid = 1'b0;
            stalled = 1'b0;
            got = 1'b1;
          end else begin
            chk(done == 1'b0, "R8 no done while stalled", 64'(done), 64'd0);
            ps = out_src; pd = out_dst; pl = out_len;
            stalled = 1'b1;
          end
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 no burst after final", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 ready after final", 64'(in_ready), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0;
    in_src = '0; in_dst = '0; in_len = '0;
    in_reps_d2 = '0; in_reps_d3 = '0;
    in_src_stride = '0; in_dst_stride = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 reset ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R8 reset no burst", 64'(out_valid), 64'd0);
    chk(done == 1'b0, "R8 reset no done", 64'(done), 64'd0);
    rst_n = 1'b1;

    // Row copy: 64-byte rows, 4 rows, source pitch 128, destination pitch 64 (R3, R4)
    run_desc(32'h1000_0000, 32'h2000_0000, 16'd64, 4, 1, 32'd128, 32'd0, 32'd64, 32'd0, 0);

    // Sweep dimension counts including zero (R5) and joint wraps (R4), under three stall patterns (R7)
    for (int r3 = 0; r3 < 4; r3++) begin
      for (int r2 = 0; r2 < 6; r2++) begin
        run_desc(32'h0000_4000 + 32'(r2 * 32'h100), 32'h8000_0000 - 32'(r3 * 32'h40),
                 16'(32 + r2 + r3), r2, r3,
                 32'h40 + 32'(r2 * 16), 32'h1000, 32'h20, 32'hFFFF_FF00, (r2 + r3) % 3);
      end
    end

    // R6: full count on both dimensions at their own widths
    run_desc(32'h0000_0100, 32'h0001_0000, 16'd8, 15, 7, 32'd8, 32'h200, 32'd16, 32'h400, 1);

    // R3: address arithmetic wraps modulo 2^ADDR_W
    run_desc(32'hFFFF_FFC0, 32'hFFFF_FFF0, 16'd16, 3, 2, 32'h20, 32'h100, 32'h8, 32'h10, 2);

    summary();
    $finish;
  end

endmodule